// File: doc/BRIEF.md
# Receive Lane Synchronization and Alignment Tracker

This block sits on one receive lane of a multi-gigabit converter link, behind the 8b/10b decoder. Each link clock it takes one 32-bit word made of four octets. Each octet comes with a control-character flag and with decode-error and disparity-error flags. The block holds the synchronization request line low until it has seen a run of clean comma characters. It then follows the lane alignment sequence that the transmitter sends: four multiframes, each opened by a start marker and closed by an alignment marker. From the second multiframe it copies the fourteen link-parameter octets into four 32-bit words.

When the closing marker of the last alignment multiframe arrives, the block declares the lane aligned. From then on it flags the word that opens each multiframe of user data. If any expected boundary marker is missing, the block drops back to requesting synchronization. An error output latches any code or disparity error seen while synchronization is being established.

The design assumes that the transmitter places the sequence on word boundaries: every multiframe starts at octet 0 of a word. Octet 0 occupies bits 7:0 of the word.

Top module: `jrx_lane_tracker`

## Requirements
- R1: After reset, syncN is 0, laneAligned is 0, somf is 0, errIrq is 0 and all four configuration words are 0.
- R2: An octet counts as a comma when its flag is set, its value is 0xBC and neither error flag is set. The start marker is a flagged 0x1C, the parameter marker is a flagged 0x9C and the alignment marker is a flagged 0x7C. The same value with the flag clear is plain data.
- R3: syncN goes high the cycle after the word in which a run of KMIN (4) consecutive commas is completed. The run is counted octet by octet in order 0 to 3 and carries across word boundaries. Any other octet, including a comma with an error flag, restarts the run.
- R4: After release, all-comma words keep syncN high. The first word that is not all commas starts the alignment sequence if its octet 0 is a start marker. Otherwise syncN returns to 0 the next cycle.
- R5: The alignment sequence is 4 multiframes of MF_WORDS (8) words. Octet 0 of each multiframe's first word must be a start marker, and octet 3 of each multiframe's last word must be an alignment marker. Any violation drives syncN to 0 the next cycle.
- R6: In the second multiframe, octet 1 of the first word must be the parameter marker, or the lane resynchronizes. The 14 octets at multiframe positions 2 to 15 are stored so that parameter octet j lands in cfg(j/4) at bits 8*(j%4)+7 to 8*(j%4). The top 16 bits of cfg3 stay 0, and the stored values change only while that multiframe is received or when a new sequence starts.
- R7: laneAligned is 1 from the cycle after the final alignment marker word and stays 1 while syncN is 1.
- R8: During user data, somf is 4'b0001 on the cycle in which the first word of a multiframe is presented, counting MF_WORDS words from the first user-data word. Otherwise somf is 0.
- R9: errIrq sets the cycle after a valid word that carries any decode or disparity error while the lane is not yet in the alignment sequence or user data. It then stays set until reset. Errors during the alignment sequence or user data leave it unchanged.
- R10: A word presented with rxValid low is ignored. syncN, laneAligned, somf, errIrq and the count of consecutive commas do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxValid | input | 1 | Word from decoder is valid |
| rxData | input | 32 | Four received octets, octet 0 in bits 7:0 |
| rxKFlag | input | 4 | Control-character flag per octet |
| rxDecErr | input | 4 | Decode error per octet |
| rxDispErr | input | 4 | Disparity error per octet |
| syncN | output | 1 | Synchronization request, active low |
| laneAligned | output | 1 | Lane has finished the alignment sequence |
| somf | output | 4 | Start-of-multiframe marker per octet position |
| errIrq | output | 1 | Sticky code error seen during synchronization |
| cfg0 | output | 32 | Link parameter octets 0 to 3 |
| cfg1 | output | 32 | Link parameter octets 4 to 7 |
| cfg2 | output | 32 | Link parameter octets 8 to 11 |
| cfg3 | output | 32 | Link parameter octets 12 and 13 |

## Verification
The assertions check, on every cycle, the invariants that hold in any state. A release of syncN follows a valid word. Alignment rises only after a closing marker in octet 3. The error flag is sticky and has a cause. An invalid word freezes the outputs. The stored parameters are stable outside capture. Only the bench scenarios can show the sequence-dependent behaviour: comma runs that straddle word boundaries, runs broken by errored commas, recovery from a missing marker, the exact byte placement of the parameters, and the period of the multiframe flag in user data.

// File: rtl/jrx_pkg.sv
package jrx_pkg;
  localparam logic [7:0] CH_COMMA = 8'hBC;
  localparam logic [7:0] CH_START = 8'h1C;
  localparam logic [7:0] CH_PARAM = 8'h9C;
  localparam logic [7:0] CH_ALIGN = 8'h7C;

  // number of link parameter octets and their first position in multiframe 1
  localparam int CFG_OCT  = 14;
  localparam int CFG_POS0 = 2;
  localparam int CFG_SLOTS = 16;

  typedef enum logic [1:0] {
    ST_CGS  = 2'd0,
    ST_WAIT = 2'd1,
    ST_ILAS = 2'd2,
    ST_DATA = 2'd3
  } lane_st_e;

  typedef struct packed {
    logic       capEn;
    logic [7:0] capWd;
    logic       clrCfg;
  } dp_strobe_t;
endpackage

// File: rtl/jrx_octet_class.sv
module jrx_octet_class #(
  parameter int NOCT = 4
) (
  input  logic [8*NOCT-1:0] rxData,
  input  logic [NOCT-1:0]   rxKFlag,
  input  logic [NOCT-1:0]   rxDecErr,
  input  logic [NOCT-1:0]   rxDispErr,
  output logic [NOCT-1:0]   goodK,
  output logic              leadStart,
  output logic              secondParam,
  output logic              tailAlign,
  output logic              anyErr
);
  import jrx_pkg::*;

  for (genvar o = 0; o < NOCT; o++) begin : g_oct
    assign goodK[o] = rxKFlag[o] && (rxData[8*o +: 8] == CH_COMMA)
                      && !rxDecErr[o] && !rxDispErr[o];
  end

  assign leadStart   = rxKFlag[0] && (rxData[7:0] == CH_START);
  assign secondParam = rxKFlag[1] && (rxData[15:8] == CH_PARAM);
  assign tailAlign   = rxKFlag[NOCT-1] && (rxData[8*NOCT-1 -: 8] == CH_ALIGN);
  assign anyErr      = |(rxDecErr | rxDispErr);
endmodule

// File: rtl/jrx_lane_ctrl.sv
module jrx_lane_ctrl #(
  parameter int NOCT     = 4,
  parameter int MF_WORDS = 8,
  parameter int ILAS_MF  = 4,
  parameter int KMIN     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxValid,
  input  logic [NOCT-1:0]    goodK,
  input  logic               leadStart,
  input  logic               secondParam,
  input  logic               tailAlign,
  input  logic               anyErr,
  output jrx_pkg::dp_strobe_t strobe,
  output logic               syncN,
  output logic               laneAligned,
  output logic [NOCT-1:0]    somf,
  output logic               errIrq
);
  import jrx_pkg::*;

  localparam int WD_W  = (MF_WORDS > 1) ? $clog2(MF_WORDS) : 1;
  localparam int MF_W  = (ILAS_MF > 1) ? $clog2(ILAS_MF) : 1;
  localparam int RUN_W = $clog2(KMIN + 1);

  lane_st_e        state, stNext;
  logic [WD_W-1:0] wdIdx, wdNext;
  logic [MF_W-1:0] mfIdx, mfNext;
  logic [RUN_W-1:0] kRun, kRunNext, runScan;
  logic            runHit;
  logic            errNext;
  logic            lastWd, lastMf, ilasFail;

  assign lastWd = (wdIdx == WD_W'(MF_WORDS - 1));
  assign lastMf = (mfIdx == MF_W'(ILAS_MF - 1));

  // octet-serial comma run over the word
  always_comb begin
    runScan = kRun;
    runHit  = 1'b0;
    for (int o = 0; o < NOCT; o++) begin
      if (goodK[o]) begin
        if (runScan < RUN_W'(KMIN)) runScan = runScan + 1'b1;
      end else begin
        runScan = '0;
      end
      if (runScan == RUN_W'(KMIN)) runHit = 1'b1;
    end
  end

  always_comb begin
    ilasFail = 1'b0;
    if (wdIdx == '0) begin
      if (!leadStart) ilasFail = 1'b1;
      if ((mfIdx == MF_W'(1)) && !secondParam) ilasFail = 1'b1;
    end
    if (lastWd && !tailAlign) ilasFail = 1'b1;
  end

  always_comb begin
    stNext        = state;
    wdNext        = wdIdx;
    mfNext        = mfIdx;
    kRunNext      = kRun;
    strobe.capEn  = 1'b0;
    strobe.capWd  = 8'(wdIdx);
    strobe.clrCfg = 1'b0;
    errNext       = errIrq;
    if (rxValid) begin
      if (((state == ST_CGS) || (state == ST_WAIT)) && anyErr) errNext = 1'b1;
      case (state)
        ST_CGS: begin
          kRunNext = runScan;
          if (runHit) stNext = ST_WAIT;
        end
        ST_WAIT: begin
          if (&goodK) begin
            stNext = ST_WAIT;
          end else if (leadStart) begin
            stNext        = ST_ILAS;
            wdNext        = WD_W'(1);
            mfNext        = '0;
            strobe.clrCfg = 1'b1;
          end else begin
            stNext   = ST_CGS;
            kRunNext = '0;
          end
        end
        ST_ILAS: begin
          if (ilasFail) begin
            stNext   = ST_CGS;
            kRunNext = '0;
          end else begin
            strobe.capEn = (mfIdx == MF_W'(1));
            if (lastWd) begin
              wdNext = '0;
              if (lastMf) stNext = ST_DATA;
              else        mfNext = mfIdx + 1'b1;
            end else begin
              wdNext = wdIdx + 1'b1;
            end
          end
        end
        default: begin
          wdNext = lastWd ? '0 : wdIdx + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_CGS;
      wdIdx  <= '0;
      mfIdx  <= '0;
      kRun   <= '0;
      errIrq <= 1'b0;
    end else begin
      state  <= stNext;
      wdIdx  <= wdNext;
      mfIdx  <= mfNext;
      kRun   <= kRunNext;
      errIrq <= errNext;
    end
  end

  assign syncN       = (state != ST_CGS);
  assign laneAligned = (state == ST_DATA);
  assign somf        = {{(NOCT-1){1'b0}}, (state == ST_DATA) && (wdIdx == '0)};

  // R3: comma run never exceeds its saturation point
  p_run_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    kRun <= RUN_W'(KMIN));
  // R5: a lane in the sequence only leaves it for CGS or user data
  p_ilas_exit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ILAS) |=> (state inside {ST_ILAS, ST_CGS, ST_DATA}));
endmodule

// File: rtl/jrx_cfg_store.sv
module jrx_cfg_store #(
  parameter int NOCT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [8*NOCT-1:0]   rxData,
  input  jrx_pkg::dp_strobe_t strobe,
  output logic [8*jrx_pkg::CFG_SLOTS-1:0] cfgFlat
);
  import jrx_pkg::*;

  for (genvar j = 0; j < CFG_OCT; j++) begin : g_cap
    localparam int POS = j + CFG_POS0;
    localparam int WD  = POS / NOCT;
    localparam int OC  = POS % NOCT;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   cfgFlat[8*j +: 8] <= '0;
      else if (strobe.clrCfg)                      cfgFlat[8*j +: 8] <= '0;
      else if (strobe.capEn && strobe.capWd == 8'(WD)) cfgFlat[8*j +: 8] <= rxData[8*OC +: 8];
    end
  end

  for (genvar j = CFG_OCT; j < CFG_SLOTS; j++) begin : g_pad
    assign cfgFlat[8*j +: 8] = '0;
  end

  // R6: stored parameters hold outside capture and clear
  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.capEn && !strobe.clrCfg) |=> $stable(cfgFlat));
endmodule

// File: rtl/jrx_lane_tracker.sv
module jrx_lane_tracker #(
  parameter int NOCT     = 4,
  parameter int MF_WORDS = 8,
  parameter int ILAS_MF  = 4,
  parameter int KMIN     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [8*NOCT-1:0] rxData,
  input  logic [NOCT-1:0]   rxKFlag,
  input  logic [NOCT-1:0]   rxDecErr,
  input  logic [NOCT-1:0]   rxDispErr,
  output logic              syncN,
  output logic              laneAligned,
  output logic [NOCT-1:0]   somf,
  output logic              errIrq,
  output logic [31:0]       cfg0,
  output logic [31:0]       cfg1,
  output logic [31:0]       cfg2,
  output logic [31:0]       cfg3
);
  import jrx_pkg::*;

  logic [NOCT-1:0] goodK;
  logic            leadStart, secondParam, tailAlign, anyErr;
  dp_strobe_t      strobe;
  logic [8*CFG_SLOTS-1:0] cfgFlat;

  jrx_octet_class #(.NOCT(NOCT)) u_class (
    .rxData(rxData), .rxKFlag(rxKFlag), .rxDecErr(rxDecErr), .rxDispErr(rxDispErr),
    .goodK(goodK), .leadStart(leadStart), .secondParam(secondParam),
    .tailAlign(tailAlign), .anyErr(anyErr)
  );

  jrx_lane_ctrl #(.NOCT(NOCT), .MF_WORDS(MF_WORDS), .ILAS_MF(ILAS_MF), .KMIN(KMIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .goodK(goodK), .leadStart(leadStart),
    .secondParam(secondParam), .tailAlign(tailAlign), .anyErr(anyErr), .strobe(strobe),
    .syncN(syncN), .laneAligned(laneAligned), .somf(somf), .errIrq(errIrq)
  );

  jrx_cfg_store #(.NOCT(NOCT)) u_cfg (
    .clk(clk), .rstN(rstN), .rxData(rxData), .strobe(strobe), .cfgFlat(cfgFlat)
  );

  assign cfg0 = cfgFlat[31:0];
  assign cfg1 = cfgFlat[63:32];
  assign cfg2 = cfgFlat[95:64];
  assign cfg3 = cfgFlat[127:96];

  // R3: release of the request line always follows an accepted word
  p_release_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncN) |-> $past(rxValid));
  // R7: alignment rises only after a closing marker in the last octet
  p_align_marker_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(laneAligned) |-> $past(rxValid && rxKFlag[NOCT-1] && (rxData[8*NOCT-1 -: 8] == CH_ALIGN)));
  // R7: an aligned lane never requests synchronization
  p_align_sync_r7: assert property (@(posedge clk) disable iff (!rstN)
    laneAligned |-> syncN);
  // R8: multiframe flag only during user data, one position at most
  p_somf_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    (somf != '0) |-> (laneAligned && $onehot0(somf)));
  // R9: error flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |=> errIrq);
  // R9: error flag rises only after an errored valid word before alignment
  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errIrq) |-> $past(rxValid && (|(rxDecErr | rxDispErr)) && !laneAligned));
  // R10: an invalid word freezes the status outputs
  p_hold_invalid_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> ($stable(syncN) && $stable(laneAligned) && $stable(errIrq) && $stable(somf)));
endmodule

// File: tb/sim_jrx_lane_tracker.sv
module sim_jrx_lane_tracker;
  localparam int MFW = 8;
  localparam int NMF = 4;
  localparam logic [31:0] KWORD = 32'hBCBCBCBC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxValid = 1'b0;
  logic [31:0] rxData = '0;
  logic [3:0] rxKFlag = '0, rxDecErr = '0, rxDispErr = '0;
  logic syncN, laneAligned, errIrq;
  logic [3:0] somf;
  logic [31:0] cfg0, cfg1, cfg2, cfg3;

  int nChk = 0;
  int nFail = 0;
  logic [7:0] cfgB [14];

  always #10 clk = ~clk;

  jrx_lane_tracker u0 (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxKFlag(rxKFlag),
    .rxDecErr(rxDecErr), .rxDispErr(rxDispErr), .syncN(syncN), .laneAligned(laneAligned),
    .somf(somf), .errIrq(errIrq), .cfg0(cfg0), .cfg1(cfg1), .cfg2(cfg2), .cfg3(cfg3)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] d, input logic [3:0] k,
                      input logic [3:0] de = 4'h0, input logic [3:0] dp = 4'h0,
                      input logic v = 1'b1);
    @(negedge clk);
    rxData = d; rxKFlag = k; rxDecErr = de; rxDispErr = dp; rxValid = v;
    @(posedge clk);
    #2;
    rxValid = 1'b0; rxDecErr = '0; rxDispErr = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0; rxValid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic logic [31:0] cfgExp(input int r);
    logic [31:0] w = '0;
    for (int j = 0; j < 14; j++)
      if (j / 4 == r) w[8*(j%4) +: 8] = cfgB[j];
    return w;
  endfunction

  task automatic randCfg();
    for (int j = 0; j < 14; j++) cfgB[j] = 8'($urandom);
  endtask

  // badKind: 0 clean, 1 no closing marker in multiframe 2, 2 no parameter marker
  task automatic sendIlas(input int badKind, input bit stall);
    for (int mf = 0; mf < NMF; mf++) begin
      for (int wd = 0; wd < MFW; wd++) begin
        logic [31:0] d;
        logic [3:0] k;
        d = $urandom; k = '0;
        for (int o = 0; o < 4; o++) begin
          int p;
          p = wd * 4 + o;
          if (p == 0) begin d[7:0] = 8'h1C; k[0] = 1'b1; end
          if (mf == 1 && p == 1 && badKind != 2) begin d[15:8] = 8'h9C; k[1] = 1'b1; end
          if (mf == 1 && p >= 2 && p < 16) d[8*o +: 8] = cfgB[p-2];
          if (wd == MFW-1 && o == 3 && !(badKind == 1 && mf == 2)) begin
            d[31:24] = 8'h7C; k[3] = 1'b1;
          end
        end
        if (stall && ($urandom % 4 == 0)) push(KWORD, 4'hF, 4'hF, 4'h0, 1'b0);
        push(d, k);
        if (mf == 0 && wd == 0) begin
          chk("R4", "syncN in sequence", 32'(syncN), 1);
          chk("R7", "aligned in sequence", 32'(laneAligned), 0);
        end
      end
    end
  endtask

  task automatic checkCfg(input string tag);
    chk("R6", {tag, " cfg0"}, cfg0, cfgExp(0));
    chk("R6", {tag, " cfg1"}, cfg1, cfgExp(1));
    chk("R6", {tag, " cfg2"}, cfg2, cfgExp(2));
    chk("R6", {tag, " cfg3"}, cfg3, cfgExp(3));
  endtask

  initial begin
    #(20 * 190000);
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    doReset();
    #1;
    // R1 reset state
    chk("R1", "syncN", 32'(syncN), 0);
    chk("R1", "laneAligned", 32'(laneAligned), 0);
    chk("R1", "somf", 32'(somf), 0);
    chk("R1", "errIrq", 32'(errIrq), 0);
    chk("R1", "cfg0", cfg0, 0);
    chk("R1", "cfg3", cfg3, 0);

    // R10 invalid words with commas and errors are ignored
    push(KWORD, 4'hF, 4'hF, 4'hF, 1'b0);
    push(KWORD, 4'hF, 4'h0, 4'h0, 1'b0);
    chk("R10", "syncN after invalid", 32'(syncN), 0);
    chk("R10", "errIrq after invalid", 32'(errIrq), 0);

    // R3 run broken by data octet, then by errored comma, completed across words
    push(32'hBC00BCBC, 4'b1011);
    chk("R3", "run broken by data", 32'(syncN), 0);
    push(KWORD, 4'hF, 4'h0, 4'b0001);
    chk("R3", "errored comma breaks run", 32'(syncN), 0);
    chk("R9", "errIrq on disparity in CGS", 32'(errIrq), 1);
    push(32'h000000BC, 4'b0001);
    chk("R3", "run across word boundary", 32'(syncN), 1);
    push(KWORD, 4'hF);
    chk("R4", "comma word keeps release", 32'(syncN), 1);
    // R4 word not all commas without start marker in octet 0
    push(32'h00001CBC, 4'b0011);
    chk("R4", "bad sequence start", 32'(syncN), 0);
    chk("R9", "errIrq sticky", 32'(errIrq), 1);

    // R2 unflagged comma value is data
    doReset();
    push(KWORD, 4'h0);
    chk("R2", "unflagged commas", 32'(syncN), 0);
    push(KWORD, 4'hF);
    chk("R2", "flagged commas", 32'(syncN), 1);
    randCfg();
    sendIlas(0, 1'b0);
    chk("R7", "aligned after sequence", 32'(laneAligned), 1);
    chk("R8", "somf first data word", 32'(somf), 1);
    checkCfg("directed");
    for (int i = 1; i <= 12; i++) begin
      push($urandom, 4'h0);
      chk("R8", "somf period", 32'(somf), (i % MFW == 0) ? 1 : 0);
    end
    push(KWORD, 4'hF, 4'h0, 4'h0, 1'b0);
    chk("R10", "somf frozen on invalid", 32'(somf), 0);
    push($urandom, 4'h0, 4'hF, 4'hF);
    chk("R9", "no error flag in data", 32'(errIrq), 0);
    chk("R7", "aligned holds", 32'(laneAligned), 1);
    checkCfg("after data");

    // R5 missing closing marker
    doReset();
    push(KWORD, 4'hF);
    randCfg();
    sendIlas(1, 1'b0);
    chk("R5", "missing closing marker", 32'(syncN), 0);
    chk("R5", "not aligned", 32'(laneAligned), 0);

    // R6 missing parameter marker, then recovery
    doReset();
    push(KWORD, 4'hF);
    sendIlas(2, 1'b0);
    chk("R6", "missing parameter marker", 32'(syncN), 0);
    push(KWORD, 4'hF);
    chk("R3", "release after recovery", 32'(syncN), 1);
    randCfg();
    sendIlas(0, 1'b0);
    chk("R7", "aligned after recovery", 32'(laneAligned), 1);
    checkCfg("recovery");

    // random runs
    for (int it = 0; it < 25; it++) begin
      int pre;
      doReset();
      pre = 1 + int'($urandom % 5);
      for (int n = 0; n < pre; n++) push(KWORD, 4'hF);
      chk("R3", "random release", 32'(syncN), 1);
      randCfg();
      sendIlas(0, 1'b1);
      chk("R7", "random aligned", 32'(laneAligned), 1);
      chk("R9", "random no error", 32'(errIrq), 0);
      checkCfg("random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule